// File: doc/BRIEF.md
# Buffered-Modulus PWM Period Counter

This block is the time base of a pulse-width modulator. It holds a 12-bit counter that either climbs from 1 to a limit and restarts (edge-aligned operation) or climbs to the limit and falls back to 0 (center-aligned operation). The limit, called the modulus, is written by software over an 8-bit register bus in two bytes. The block also reports the counting direction and raises a one-cycle strobe at the start of every period.

The modulus is double buffered. Bus writes land in a buffer that software can read back. The counter keeps using its active copy until software sets an arm flag and the next period boundary arrives. At that boundary the buffer and the requested mode move into the active set, and the arm flag clears itself. Writing either modulus byte drops the arm flag, so a value that is only half written never reaches the counter. An active modulus of zero is not a legal setting. In that case the counter runs downward without end and wraps from 0 to the all-ones value.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction flag is low (up), the period strobe is low, and the control register reads 0 (arm clear, edge-aligned mode selected, counter stopped).
- R2: In edge-aligned mode with active modulus M > 0, the count steps 1, 2, ..., M and then returns to 1. A period lasts M cycles, the strobe is high in the cycle the count is 1, and the peak count is M.
- R3: In center-aligned mode with active modulus M > 0, the count rises to M and falls to 0, and a period lasts 2M cycles. The strobe is high in the cycle the count is 1 at the start of the rising leg. The direction flag is high exactly when the current count came from a decrement.
- R4: Bus address 0 holds modulus bits 11..8 in data bits 3..0, and its data bits 7..4 read 0 and ignore writes. Address 1 holds modulus bits 7..0. Reads of both addresses return the buffered value, not the active one.
- R5: The buffered modulus and the mode bit become active only at a period boundary, and only if the arm flag is set at that boundary. With the arm flag clear, the period stays unchanged.
- R6: A bus write to address 0 or 1 clears the arm flag.
- R7: A transfer at a period boundary clears the arm flag.
- R8: While the active modulus is 0, the count decreases by one every cycle and wraps from 0 to 0xFFF with the direction flag high. The strobe is high in the cycle the count is 0xFFF.
- R9: While the run bit is 0, the count is 0, the direction flag is low and the strobe is low. When the run bit is set, the next count is 1 with the strobe high, which is a period boundary.
- R10: Address 2 is the control register. Bit 0 is arm (write 1 sets it, write 0 clears it), bit 1 selects center-aligned mode, and bit 2 is run. The other bits read 0. Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| count | output | 12 | Current counter value |
| dir_down | output | 1 | High while counting down |
| ld_strobe | output | 1 | High in the first cycle of each period |

## Verification
The bench builds the block with its default widths: a 12-bit counter and an 8-bit bus. With these widths the largest modulus, 0xFFF, gives periods of a few thousand cycles, so the bench can run complete periods at both ends of the range. The upper byte is only four bits wide, so the masking of its top nibble gets exercised. Random moduli from 1 to 50 in alternating modes check the period lengths and the peak counts. Directed cases then arm and disarm the load in the middle of a period, load a modulus of zero, and stop the counter.

// File: rtl/pwmtb_pkg.sv
// Package pwmtb_pkg
// Shared register addresses and control bit positions for the PWM time base.
// Assumes a 2-bit register address space.
package pwmtb_pkg;

    typedef enum logic [1:0] {
        ADDR_MOD_HI = 2'd0,
        ADDR_MOD_LO = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    localparam int CTRL_ARM_BIT    = 0;
    localparam int CTRL_CENTER_BIT = 1;
    localparam int CTRL_RUN_BIT    = 2;

    // True for either half of the modulus buffer
    function automatic logic is_mod_addr(reg_addr_e a);
        return (a == ADDR_MOD_HI) || (a == ADDR_MOD_LO);
    endfunction

endpackage

// File: rtl/pwmtb_regs.sv
// Module pwmtb_regs
// Register file of the PWM time base: the two-byte modulus buffer, which has
// no reset, and the control register (arm, mode, run).
// Assumes BUS_W < W <= 2*BUS_W. A transfer request (take) comes from the core.
module pwmtb_regs
    import pwmtb_pkg::*;
#(
    parameter int W     = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             take,
    output logic [W-1:0]     mod_buf,
    output logic             arm,
    output logic             center_sel,
    output logic             run
);
    localparam int HI_W = W - BUS_W;

    reg_addr_e         addr;
    logic [HI_W-1:0]   buf_hi;
    logic [BUS_W-1:0]  buf_lo;
    logic [BUS_W-1:0]  rd_hi;
    logic [BUS_W-1:0]  rd_ctrl;
    logic              wr_ctrl;
    logic              wr_mod;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (addr == ADDR_CTRL);
    assign wr_mod  = bus_wr && is_mod_addr(addr);
    assign mod_buf = {buf_hi, buf_lo};

    // Upper modulus field: no reset, so it holds whatever software last wrote
    always_ff @(posedge clk) begin
        if (bus_wr && addr == ADDR_MOD_HI)
            buf_hi <= bus_wdata[HI_W-1:0];
    end

    // Lower modulus byte: no reset either
    always_ff @(posedge clk) begin
        if (bus_wr && addr == ADDR_MOD_LO)
            buf_lo <= bus_wdata;
    end

    // Mode and run bits: written only through the control address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            center_sel <= 1'b0;
            run        <= 1'b0;
        end else if (wr_ctrl) begin
            center_sel <= bus_wdata[CTRL_CENTER_BIT];
            run        <= bus_wdata[CTRL_RUN_BIT];
        end
    end

    // Arm flag: a control write wins, a modulus write or a transfer drops it
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm <= 1'b0;
        else if (wr_ctrl)
            arm <= bus_wdata[CTRL_ARM_BIT];
        else if (wr_mod || take)
            arm <= 1'b0;
    end

    // Pad the narrow upper field with zeros when it is smaller than a byte
    generate
        if (HI_W < BUS_W) begin : g_hi_pad
            assign rd_hi = {{(BUS_W-HI_W){1'b0}}, buf_hi};
        end else begin : g_hi_full
            assign rd_hi = buf_hi;
        end
    endgenerate

    // Control readback: only the three defined bits are live
    always_comb begin
        rd_ctrl                  = '0;
        rd_ctrl[CTRL_ARM_BIT]    = arm;
        rd_ctrl[CTRL_CENTER_BIT] = center_sel;
        rd_ctrl[CTRL_RUN_BIT]    = run;
    end

    // Read multiplexer: modulus reads return the buffer contents
    always_comb begin
        unique case (addr)
            ADDR_MOD_HI: bus_rdata = rd_hi;
            ADDR_MOD_LO: bus_rdata = buf_lo;
            ADDR_CTRL:   bus_rdata = rd_ctrl;
            default:     bus_rdata = '0;
        endcase
    end

    // R6
    ldok_wrclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_mod_addr(addr)) |=> !arm);

    // R7
    ldok_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_ctrl) |=> !arm);

endmodule

// File: rtl/pwmtb_step.sv
// Module pwmtb_step
// Combinational next-state of the period counter. It decides the next count,
// the next direction, and whether the coming edge is a period boundary.
// Assumes mod == 0 is the illegal setting that falls back to free decrement.
module pwmtb_step #(
    parameter int W = 12
) (
    input  logic         run,
    input  logic         fresh,
    input  logic         center,
    input  logic [W-1:0] mod,
    input  logic [W-1:0] cur,
    input  logic         dir,
    output logic [W-1:0] nxt,
    output logic         nxt_dir,
    output logic         load
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic at_zero;
    logic at_top;

    assign at_zero = (cur == ZERO);
    assign at_top  = (cur >= mod);

    // Next count and direction for every mode and leg
    always_comb begin
        nxt     = cur;
        nxt_dir = dir;
        load    = 1'b0;
        if (!run) begin
            nxt     = ZERO;
            nxt_dir = 1'b0;
        end else if (fresh) begin
            nxt     = ONE;
            nxt_dir = 1'b0;
            load    = 1'b1;
        end else if (mod == ZERO) begin
            nxt     = cur - ONE;
            nxt_dir = 1'b1;
            load    = at_zero;
        end else if (!center) begin
            nxt_dir = 1'b0;
            if (at_zero || at_top) begin
                nxt  = ONE;
                load = 1'b1;
            end else begin
                nxt = cur + ONE;
            end
        end else if (dir) begin
            if (at_zero) begin
                nxt     = ONE;
                nxt_dir = 1'b0;
                load    = 1'b1;
            end else begin
                nxt     = cur - ONE;
                nxt_dir = 1'b1;
            end
        end else begin
            if (at_zero) begin
                nxt  = ONE;
                load = 1'b1;
            end else if (at_top) begin
                nxt     = cur - ONE;
                nxt_dir = 1'b1;
            end else begin
                nxt = cur + ONE;
            end
        end
    end

endmodule

// File: rtl/pwmtb_core.sv
// Module pwmtb_core
// Holds the active modulus and mode, and the counter, direction and strobe
// registers. At a period boundary with the arm flag set, it takes over the
// buffer. Assumes run, arm, mode and buffer come from registers.
module pwmtb_core #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         center_sel,
    input  logic         arm,
    input  logic [W-1:0] mod_buf,
    output logic [W-1:0] count,
    output logic         dir_down,
    output logic         ld_strobe,
    output logic         take
);
    logic [W-1:0] cnt_q;
    logic         dir_q;
    logic         stb_q;
    logic         running_q;
    logic [W-1:0] act_mod_q;
    logic         center_q;
    logic [W-1:0] nxt;
    logic         nxt_dir;
    logic         load;

    pwmtb_step #(.W(W)) u_step (
        .run     (run),
        .fresh   (run && !running_q),
        .center  (center_q),
        .mod     (act_mod_q),
        .cur     (cnt_q),
        .dir     (dir_q),
        .nxt     (nxt),
        .nxt_dir (nxt_dir),
        .load    (load)
    );

    assign take      = load && arm;
    assign count     = cnt_q;
    assign dir_down  = dir_q;
    assign ld_strobe = stb_q;

    // Counter, direction and period strobe advance every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            dir_q     <= 1'b0;
            stb_q     <= 1'b0;
            running_q <= 1'b0;
        end else begin
            cnt_q     <= nxt;
            dir_q     <= nxt_dir;
            stb_q     <= load;
            running_q <= run;
        end
    end

    // Active modulus and mode change only on an armed boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mod_q <= '0;
            center_q  <= 1'b0;
        end else if (take) begin
            act_mod_q <= mod_buf;
            center_q  <= center_sel;
        end
    end

    // R9
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0 && !dir_q && !stb_q));

    // R2
    edge_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !center_q && act_mod_q != '0 && cnt_q >= act_mod_q) |=> cnt_q == W'(1));

    // R3
    center_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && center_q && act_mod_q != '0 && dir_q && cnt_q == '0) |=> (cnt_q == W'(1) && !dir_q));

    // R2
    strobe_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q && !dir_q) |-> cnt_q == W'(1));

endmodule

// File: rtl/pwm_timebase.sv
// Module pwm_timebase
// Top of the PWM time base: the register file plus the period counter core.
// Assumes a single-master register bus with a one-cycle write and a
// combinational read.
module pwm_timebase #(
    parameter int CNT_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             ld_strobe
);
    logic [CNT_W-1:0] mod_buf;
    logic             arm;
    logic             center_sel;
    logic             run;
    logic             take;

    pwmtb_regs #(.W(CNT_W), .BUS_W(BUS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .take       (take),
        .mod_buf    (mod_buf),
        .arm        (arm),
        .center_sel (center_sel),
        .run        (run)
    );

    pwmtb_core #(.W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .center_sel (center_sel),
        .arm        (arm),
        .mod_buf    (mod_buf),
        .count      (count),
        .dir_down   (dir_down),
        .ld_strobe  (ld_strobe),
        .take       (take)
    );

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 12;
    localparam int BUS_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic [CNT_W-1:0] count;
    logic             dir_down;
    logic             ld_strobe;

    int checks = 0;
    int failures = 0;
    int per_q[$];
    int peak_q[$];
    int since = 0;
    int peak = 0;
    int prev_cnt = 0;
    bit dir_chk_en = 1'b0;
    int dir_errs = 0;
    bit done = 1'b0;

    pwm_timebase #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
        .dir_down(dir_down), .ld_strobe(ld_strobe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Period monitor: samples shortly after each rising edge
    always @(posedge clk) begin
        #2;
        if (ld_strobe) begin
            per_q.push_back(since);
            peak_q.push_back(peak);
            since = 1;
            peak = int'(count);
        end else begin
            since = since + 1;
            if (int'(count) > peak) peak = int'(count);
        end
        if (dir_chk_en) begin
            if (int'(count) > prev_cnt && dir_down) dir_errs++;
            if (int'(count) < prev_cnt && !dir_down) dir_errs++;
        end
        prev_cnt = int'(count);
    end

    function automatic int exp_period(int m, bit ctr);
        return ctr ? 2 * m : m;
    endfunction

    function automatic logic [7:0] ctrl_word(bit arm, bit ctr, bit run);
        return {5'b0, run, ctr, arm};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_strobes(input int n);
        int seen = 0;
        while (seen < n) begin
            @(negedge clk);
            if (ld_strobe) seen++;
        end
    endtask

    task automatic set_mod(input int m);
        bus_write(2'd0, 8'(m >> 8));
        bus_write(2'd1, 8'(m & 255));
    endtask

    // Load a modulus and mode, then check two full periods and their peaks
    task automatic run_period(input int m, input bit ctr, input string req);
        wait_strobes(1);
        set_mod(m);
        bus_write(2'd2, ctrl_word(1'b1, ctr, 1'b1));
        wait_strobes(1);
        per_q.delete(); peak_q.delete();
        wait_strobes(2);
        #3;
        chk(per_q.size() >= 2 && per_q[0] == exp_period(m, ctr) && per_q[1] == exp_period(m, ctr),
            req, per_q.size() >= 2 ? per_q[1] : -1, exp_period(m, ctr));
        chk(peak_q.size() >= 2 && peak_q[1] == m, req, peak_q.size() >= 2 ? peak_q[1] : -1, m);
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(count == 0, "R1 count", int'(count), 0);
        chk(!dir_down && !ld_strobe, "R1 dir/strobe", {dir_down, ld_strobe}, 0);
        bus_read(2'd2, d);
        chk(d == 8'h00, "R1 ctrl", d, 0);
        // R10 spare address
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, d);
        chk(d == 8'h00, "R10 spare", d, 0);
        // R4 byte layout and masking
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, d);
        chk(d == 8'h0F, "R4 hi mask", d, 8'h0F);
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, d);
        chk(d == 8'hA5, "R4 lo", d, 8'hA5);
        // R10 control encoding
        bus_write(2'd2, 8'hFA);
        bus_read(2'd2, d);
        chk(d == 8'h02, "R10 ctrl bits", d, 8'h02);
        bus_write(2'd2, 8'h00);
        chk(count == 0, "R10 run clear", int'(count), 0);

        // R9 start: first count is 1 with strobe
        set_mod(20);
        bus_write(2'd2, ctrl_word(1'b1, 1'b0, 1'b1));
        @(negedge clk);
        chk(count == 1 && ld_strobe, "R9 start", int'(count), 1);
        bus_read(2'd2, d);
        chk(d == 8'h04, "R7 arm cleared", d, 8'h04);
        per_q.delete(); peak_q.delete();
        wait_strobes(3);
        #3;
        chk(per_q.size() >= 2 && per_q[1] == 20, "R2 edge 20", per_q.size() >= 2 ? per_q[1] : -1, 20);

        run_period(40, 1'b0, "R2 edge 40");

        // R4/R5: buffer read without arm does not change the period
        wait_strobes(1);
        bus_write(2'd1, 8'd9);
        bus_read(2'd1, d);
        chk(d == 8'd9, "R4 buffer read", d, 9);
        per_q.delete();
        wait_strobes(2);
        #3;
        chk(per_q.size() >= 2 && per_q[0] == 40 && per_q[1] == 40, "R5 no arm", per_q.size() >= 2 ? per_q[1] : -1, 40);

        // R6: a modulus write drops the arm flag
        wait_strobes(1);
        bus_write(2'd2, ctrl_word(1'b1, 1'b0, 1'b1));
        bus_write(2'd0, 8'h00);
        bus_read(2'd2, d);
        chk(d[0] == 1'b0, "R6 arm dropped", d[0], 0);
        per_q.delete();
        wait_strobes(2);
        #3;
        chk(per_q.size() >= 2 && per_q[0] == 40 && per_q[1] == 40, "R6 no transfer", per_q.size() >= 2 ? per_q[1] : -1, 40);

        // R5: arm mid-period, current period keeps old modulus
        wait_strobes(1);
        bus_write(2'd2, ctrl_word(1'b1, 1'b0, 1'b1));
        per_q.delete();
        wait_strobes(2);
        #3;
        chk(per_q.size() >= 2 && per_q[0] == 40, "R5 old period", per_q.size() >= 1 ? per_q[0] : -1, 40);
        chk(per_q.size() >= 2 && per_q[1] == 9, "R5 new period", per_q.size() >= 2 ? per_q[1] : -1, 9);
        bus_read(2'd2, d);
        chk(d[0] == 1'b0, "R7 arm auto clear", d[0], 0);

        // R2/R3 random moduli in alternating modes
        for (int i = 0; i < 12; i++) begin
            int m = 1 + int'($urandom % 50);
            bit ctr = i[0];
            dir_chk_en = 1'b0;
            if (ctr) run_period(m, 1'b1, "R3 center random");
            else     run_period(m, 1'b0, "R2 edge random");
            if (ctr) begin
                dir_chk_en = 1'b1;
                wait_strobes(2);
                dir_chk_en = 1'b0;
            end
        end
        chk(dir_errs == 0, "R3 direction flag", dir_errs, 0);

        // Boundary moduli
        run_period(1, 1'b0, "R2 edge M=1");
        run_period(1, 1'b1, "R3 center M=1");
        run_period(12'hFFF, 1'b0, "R2 edge M=max");
        run_period(12'hFFF, 1'b1, "R3 center M=max");
        run_period(30, 1'b0, "R5 mode back to edge");

        // R8 zero modulus: free decrement with wrap
        wait_strobes(1);
        set_mod(0);
        bus_write(2'd2, ctrl_word(1'b1, 1'b0, 1'b1));
        wait_strobes(1);
        @(negedge clk);
        chk(count == 0, "R8 reach zero", int'(count), 0);
        @(negedge clk);
        chk(count == 12'hFFF && ld_strobe && dir_down, "R8 wrap", int'(count), 12'hFFF);
        @(negedge clk);
        chk(count == 12'hFFE && dir_down, "R8 decrement", int'(count), 12'hFFE);

        // R9 stop
        bus_write(2'd2, 8'h00);
        @(negedge clk);
        chk(count == 0 && !dir_down && !ld_strobe, "R9 stopped", int'(count), 0);
        repeat (3) @(negedge clk);
        chk(count == 0 && !ld_strobe, "R9 held", int'(count), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule